// File: doc/BRIEF.md
# Checkerboard-Phased Lookup Cell Array

This block is a rectangular array of small reconfigurable logic cells. Each cell connects only to its four orthogonal neighbours. It takes one bit from each neighbour and drives one bit back toward each. Inside a cell, a 64-bit configuration word holds four 16-entry truth tables, one per output direction. All four tables are indexed by the same four neighbour input bits. The output bits are registered, so any mix of logic and routing can be mapped onto the array as a pipelined fabric.

The cells are coloured like a checkerboard and updated in alternating phases. Each compute strobe lets only one colour evaluate, and every neighbour of that cell has the other colour. A cell therefore samples inputs that are stable while it evaluates, and data can move in any direction without races. The configuration is not addressed: it enters through a single scan chain that runs through every cell in row-major order. Where the array reaches its boundary, cell inputs come from edge input buses and cell outputs appear on edge output buses.

Top module: `lut_grid`

## Requirements
- R1: Each cell's output in direction d (north=0, east=1, south=2, west=3) equals configuration bit 16*d + idx. Here idx = {west_in, south_in, east_in, north_in}, with the north input as bit 0. The north table is therefore bits [15:0], east [31:16], south [47:32] and west [63:48].
- R2: A cell's north input is the south output of the cell above it, and its south input is the north output of the cell below. Its east input is the west output of the cell to its right, and its west input is the east output of the cell to its left. Where no neighbour exists, the input comes from bit col of `edge_n_in`/`edge_s_in` or bit row of `edge_w_in`/`edge_e_in`.
- R3: Bit col of `edge_n_out` is the north output of row 0, column col. Bit col of `edge_s_out` is the south output of the last row. Bit row of `edge_w_out` is the west output of column 0, and bit row of `edge_e_out` is the east output of the last column.
- R4: Cells where (row+col) is even form colour A and the rest form colour B. The first accepted `step` after reset updates only colour A, and each later accepted `step` alternates between the colours. The colour not selected keeps its outputs.
- R5: In a cycle without an accepted `step`, no cell output changes, whatever the edge inputs do.
- R6: While `scan_en` is high, the configuration shifts one bit per clock through a single chain of 64*ROWS*COLS bits. The chain enters cell (0,0) at its bit 0, passes from bit 63 of each cell into bit 0 of the next cell in row-major order, and leaves at bit 63 of the last cell on `scan_out`. `scan_out` therefore presents the bit that was shifted in 64*ROWS*COLS clocks earlier.
- R7: While `scan_en` is high, `step` is ignored: cell outputs hold and the active colour does not advance.
- R8: While `scan_en` is low, the configuration and `scan_out` do not change.
- R9: Asserting `rst_n` low clears every cell output to zero at once and selects colour A. It leaves the configuration intact. Deassertion takes effect synchronously two clocks after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift the configuration chain this cycle |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output |
| step | input | 1 | Compute strobe: evaluate the active colour, then swap colours |
| edge_n_in | input | COLS | Inputs for the north side of row 0 |
| edge_s_in | input | COLS | Inputs for the south side of the last row |
| edge_w_in | input | ROWS | Inputs for the west side of column 0 |
| edge_e_in | input | ROWS | Inputs for the east side of the last column |
| edge_n_out | output | COLS | North outputs of row 0 |
| edge_s_out | output | COLS | South outputs of the last row |
| edge_w_out | output | ROWS | West outputs of column 0 |
| edge_e_out | output | ROWS | East outputs of the last column |

## Verification
The bench builds the array with ROWS=2 and COLS=3. Because the shape is not square, a row/column swap in the wiring or on the edge buses shows up as a wrong bit. With two rows, every cell lies on the north or south edge, so each table entry a cell uses can be reached from the edge inputs. With three columns, the middle column is driven only by its neighbours from the east and west. The 384-bit chain is small enough to load, read back in full and reload under a held strobe several times. Two random configuration images are each run through the stimulus table.

// File: rtl/lut_grid_pkg.sv
package lut_grid_pkg;
  localparam int LUT_IN = 4;
  localparam int NDIR   = 4;
  localparam int TBL    = 1 << LUT_IN;
  localparam int CFG_W  = NDIR * TBL;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;

  typedef logic [NDIR-1:0]  dir_vec_t;
  typedef logic [CFG_W-1:0] cfg_word_t;
endpackage

// File: rtl/lut_grid_rst_sync.sv
module lut_grid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lut_grid_phase.sv
module lut_grid_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic step,
  output logic go,
  output logic phase
);
  logic phase_q;
  logic phase_d;

  assign go = step & ~scan_en;

  always_comb begin
    phase_d = phase_q;
    if (go) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !scan_en) |=> (phase != $past(phase))); // R4
  AST_PHASE_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> $stable(phase)); // R7
endmodule

// File: rtl/lut_grid_cell.sv
module lut_grid_cell
  import lut_grid_pkg::*;
#(
  parameter bit COLOUR = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scan_en,
  input  logic     scan_in,
  output logic     scan_out,
  input  logic     go,
  input  logic     phase,
  input  dir_vec_t nbr_in,
  output dir_vec_t nbr_out
);
  cfg_word_t cfg_q;
  cfg_word_t cfg_d;
  dir_vec_t  out_q;
  dir_vec_t  out_d;
  dir_vec_t  lut_val;
  logic [LUT_IN-1:0] idx;
  logic      eval_en;

  assign idx = {nbr_in[DIR_W], nbr_in[DIR_S], nbr_in[DIR_E], nbr_in[DIR_N]};

  for (genvar d = 0; d < NDIR; d++) begin : g_tbl
    logic [TBL-1:0] table_bits;
    assign table_bits = cfg_q[d*TBL +: TBL];
    assign lut_val[d] = table_bits[idx];
  end

  assign eval_en = go & (phase == COLOUR);

  always_comb begin
    cfg_d = cfg_q;
    if (scan_en) cfg_d = {cfg_q[CFG_W-2:0], scan_in};
  end

  always_comb begin
    out_d = out_q;
    if (eval_en) out_d = lut_val;
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign nbr_out  = out_q;
  assign scan_out = cfg_q[CFG_W-1];

  AST_SCAN_FREEZES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> $stable(nbr_out)); // R7
  AST_OTHER_COLOUR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != COLOUR) |=> $stable(nbr_out)); // R4
  AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(nbr_out)); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (nbr_out == '0)); // R9
endmodule

// File: rtl/lut_grid.sv
module lut_grid
  import lut_grid_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic            step,
  input  logic [COLS-1:0] edge_n_in,
  input  logic [COLS-1:0] edge_s_in,
  input  logic [ROWS-1:0] edge_w_in,
  input  logic [ROWS-1:0] edge_e_in,
  output logic [COLS-1:0] edge_n_out,
  output logic [COLS-1:0] edge_s_out,
  output logic [ROWS-1:0] edge_w_out,
  output logic [ROWS-1:0] edge_e_out
);
  localparam int NCELL = ROWS * COLS;

  logic     rst_i;
  logic     go;
  logic     phase;
  dir_vec_t cell_out [ROWS][COLS];
  dir_vec_t cell_in  [ROWS][COLS];
  logic     chain    [NCELL+1];

  lut_grid_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_i)
  );

  lut_grid_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_i),
    .scan_en(scan_en),
    .step   (step),
    .go     (go),
    .phase  (phase)
  );

  assign chain[0] = scan_in;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int  POS = r * COLS + c;
      localparam bit  CLR = ((r + c) % 2) != 0;
      logic n_b, e_b, s_b, w_b;

      if (r == 0) begin : g_n_edge
        assign n_b = edge_n_in[c];
      end else begin : g_n_cell
        assign n_b = cell_out[r-1][c][DIR_S];
      end
      if (r == ROWS-1) begin : g_s_edge
        assign s_b = edge_s_in[c];
      end else begin : g_s_cell
        assign s_b = cell_out[r+1][c][DIR_N];
      end
      if (c == COLS-1) begin : g_e_edge
        assign e_b = edge_e_in[r];
      end else begin : g_e_cell
        assign e_b = cell_out[r][c+1][DIR_W];
      end
      if (c == 0) begin : g_w_edge
        assign w_b = edge_w_in[r];
      end else begin : g_w_cell
        assign w_b = cell_out[r][c-1][DIR_E];
      end

      assign cell_in[r][c] = {w_b, s_b, e_b, n_b};

      lut_grid_cell #(.COLOUR(CLR)) u_cell (
        .clk     (clk),
        .rst_n   (rst_i),
        .scan_en (scan_en),
        .scan_in (chain[POS]),
        .scan_out(chain[POS+1]),
        .go      (go),
        .phase   (phase),
        .nbr_in  (cell_in[r][c]),
        .nbr_out (cell_out[r][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_ns_out
    assign edge_n_out[c] = cell_out[0][c][DIR_N];
    assign edge_s_out[c] = cell_out[ROWS-1][c][DIR_S];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_we_out
    assign edge_w_out[r] = cell_out[r][0][DIR_W];
    assign edge_e_out[r] = cell_out[r][COLS-1][DIR_E];
  end

  assign scan_out = chain[NCELL];

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_i)
    !scan_en |=> $stable(scan_out)); // R8
  AST_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    !step |=> ($stable(edge_n_out) && $stable(edge_s_out)
               && $stable(edge_w_out) && $stable(edge_e_out))); // R5
endmodule

// File: tb/lut_grid_tb_top.sv
module lut_grid_tb_top;
  localparam int  ROWS  = 2;
  localparam int  COLS  = 3;
  localparam int  CW    = 64;
  localparam int  L     = ROWS * COLS * CW;
  localparam time T_CLK = 10ns;
  localparam int  VW    = 2*COLS + 2*ROWS + 1;
  localparam int  NVEC  = 10;
  // {step, edge_e_in, edge_w_in, edge_s_in, edge_n_in}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    11'b1_00_00_000_000, 11'b1_11_11_111_111, 11'b0_01_10_101_010,
    11'b1_01_10_101_010, 11'b1_10_01_010_101, 11'b1_00_11_110_001,
    11'b0_11_00_001_110, 11'b1_11_00_001_110, 11'b1_01_01_011_100,
    11'b1_10_10_100_011 };

  logic clk = 1'b0;
  logic rst_n, scan_en, scan_in, scan_out, step;
  logic [COLS-1:0] en_i, es_i, en_o, es_o;
  logic [ROWS-1:0] ew_i, ee_i, ew_o, ee_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [L-1:0] img;
  bit mo [ROWS][COLS][4];
  bit mphase;

  always #(T_CLK/2) clk = ~clk;

  lut_grid #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .step(step),
    .edge_n_in(en_i), .edge_s_in(es_i), .edge_w_in(ew_i), .edge_e_in(ee_i),
    .edge_n_out(en_o), .edge_s_out(es_o), .edge_w_out(ew_o), .edge_e_out(ee_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_img(input logic [31:0] seed);
    logic [31:0] x = seed;
    for (int i = 0; i < L; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      img[i] = x[7];
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int d = 0; d < 4; d++) mo[r][c][d] = 0;
    mphase = 0;
  endtask

  // R1, R2, R4: independent model of one accepted step
  task automatic model_step();
    bit snap [ROWS][COLS][4];
    snap = mo;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (((r + c) % 2) == int'(mphase)) begin
          bit n, e, s, w;
          int idx;
          n = (r == 0)      ? en_i[c] : snap[(r == 0) ? 0 : r-1][c][2];
          s = (r == ROWS-1) ? es_i[c] : snap[(r == ROWS-1) ? r : r+1][c][0];
          e = (c == COLS-1) ? ee_i[r] : snap[r][(c == COLS-1) ? c : c+1][3];
          w = (c == 0)      ? ew_i[r] : snap[r][(c == 0) ? 0 : c-1][1];
          idx = {w, s, e, n};
          for (int d = 0; d < 4; d++)
            mo[r][c][d] = img[(r*COLS + c)*CW + d*16 + idx];
        end
    mphase = !mphase;
  endtask

  // R3: edge outputs against model
  task automatic check_edges(input string req);
    logic [COLS-1:0] xn, xs;
    logic [ROWS-1:0] xw, xe;
    for (int c = 0; c < COLS; c++) begin
      xn[c] = mo[0][c][0]; xs[c] = mo[ROWS-1][c][2];
    end
    for (int r = 0; r < ROWS; r++) begin
      xw[r] = mo[r][0][3]; xe[r] = mo[r][COLS-1][1];
    end
    chk({req, " north"}, 32'(en_o), 32'(xn));
    chk({req, " south"}, 32'(es_o), 32'(xs));
    chk({req, " west"},  32'(ew_o), 32'(xw));
    chk({req, " east"},  32'(ee_o), 32'(xe));
  endtask

  task automatic apply(input logic [VW-1:0] v, input string req);
    @(negedge clk);
    {step, ee_i, ew_i, es_i, en_i} = v;
    @(negedge clk);
    if (step) model_step();
    step = 0;
    check_edges(req);
  endtask

  // R6: shift the whole image in, feed img[L-1] first
  task automatic load_img(input bit hold_step);
    for (int i = L-1; i >= 0; i--) begin
      @(negedge clk);
      scan_en = 1; scan_in = img[i]; step = hold_step;
    end
    @(negedge clk);
    scan_en = 0; step = 0;
  endtask

  task automatic run_table(input string req);
    for (int k = 0; k < NVEC; k++) apply(VEC[k], req);
  endtask

  initial begin
    rst_n = 0; scan_en = 0; scan_in = 0; step = 0;
    en_i = '0; es_i = '0; ew_i = '0; ee_i = '0;
    repeat (3) @(negedge clk);
    model_clear();
    check_edges("R9 reset state");
    rst_n = 1;
    repeat (4) @(negedge clk);

    fill_img(32'h1234_5678);
    load_img(0);
    run_table("R1 R2 R4 R5 image A");

    // R8: scan_in toggles with scan_en low, scan_out stays on the last bit
    begin
      int bad = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); scan_in = k[0];
        if (scan_out !== img[L-1]) bad++;
      end
      chk("R8 config hold", 32'(bad), 32'd0);
    end
    apply(VEC[3], "R8 function after idle scan_in");

    // R7: reload with step held high, outputs and colour must not move
    @(negedge clk);
    {ee_i, ew_i, es_i, en_i} = VEC[4][VW-2:0];
    load_img(1);
    check_edges("R7 outputs held during scan");
    apply(VEC[5], "R7 colour order kept");

    // R6: read the chain out while feeding it back in
    begin
      int bad = 0;
      for (int k = 0; k < L; k++) begin
        @(negedge clk);
        if (scan_out !== img[L-1-k]) bad++;
        scan_en = 1; scan_in = img[L-1-k];
      end
      @(negedge clk); scan_en = 0;
      chk("R6 scan_out order", 32'(bad), 32'd0);
    end
    apply(VEC[8], "R6 function after rotate");

    // R9: reset mid-run keeps config, clears outputs, restarts on colour A
    apply(VEC[1], "R4 odd step count");
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    model_clear();
    check_edges("R9 outputs cleared");
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_table("R9 config kept after reset");

    fill_img(32'hCAFE_0B0E);
    load_img(0);
    run_table("R1 R2 R3 image B");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule